// File: doc/BRIEF.md
# Pipelined Four-Key Sorting Network

This block puts four unsigned keys into ascending order. It uses five compare-exchange cells arranged in three layers. Every layer is followed by a register stage. A key set on the input is accepted in any cycle where the input strobe is high, and its sorted result shows up three cycles later. The pipeline therefore takes a new set every clock cycle and needs no stall path.

The first layer sorts lanes 0–1 and lanes 2–3. The second layer compares the two lower results with each other and the two upper results with each other. After the second layer, lane 0 already holds the minimum and lane 3 already holds the maximum. The third layer only orders the two middle lanes. The block exposes the two extreme values one cycle early on their own strobe, for consumers that need only the minimum or the maximum.

Lane 0 of every key vector corresponds to the first wire. In the output, lane 0 holds the smallest key and lane 3 the largest.

Top module: `sort4_pipe`

## Requirements
- R1: When `out_valid_o` is high, `out_keys_o` lane 0 ≤ lane 1 ≤ lane 2 ≤ lane 3, compared as unsigned.
- R2: The four keys on `out_keys_o` are a permutation of the four keys of the matching input set, so duplicates are kept.
- R3: `out_valid_o` is high in cycle t+3 exactly when `in_valid_i` was high in cycle t, and the keys it qualifies come from that cycle's set.
- R4: Sets presented in consecutive cycles each produce their own sorted result in consecutive cycles, in the same order.
- R5: `early_valid_o` is high in cycle t+2 exactly when `in_valid_i` was high in cycle t. At that point `early_min_o` and `early_max_o` hold that set's minimum and maximum, and they equal lanes 0 and 3 of `out_keys_o` one cycle later.
- R6: While `rst_ni` is low, `out_valid_o` and `early_valid_o` are low. A set that is in flight when reset arrives never produces a valid output.
- R7: The input lanes 0..3 = 9, 5, 2, 6 give the output lanes 0..3 = 2, 5, 6, 9.
- R8: All-equal keys and keys at the range ends (0 and all-ones) come out unchanged in value and correctly ordered.
- R9: A cycle with `in_valid_i` low yields a cycle with `out_valid_o` low three cycles later, and `early_valid_o` low two cycles later, whatever keys were on the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the valid flags |
| in_valid_i | input | 1 | Key set on `in_keys_i` is valid this cycle |
| in_keys_i | input | 4×DATA_W | Four unsigned keys, lane 0 in the low bits |
| out_valid_o | output | 1 | Sorted set on `out_keys_o` is valid |
| out_keys_o | output | 4×DATA_W | Keys in ascending order, smallest in lane 0 |
| early_valid_o | output | 1 | Early extremes are valid, one cycle ahead of `out_valid_o` |
| early_min_o | output | DATA_W | Minimum of the set, available after two layers |
| early_max_o | output | DATA_W | Maximum of the set, available after two layers |

## Verification
The bench tries the following key patterns:

- Already ascending and fully descending sets. These show whether each layer drives min and max to the correct lanes.
- The 9, 5, 2, 6 case. Here the first two layers leave the middle pair out of order, so it shows whether the third layer exists and is wired to lanes 1–2.
- All-equal keys, repeated keys and keys at 0 and all-ones. These expose a strict-versus-non-strict compare, or lost duplicates.

All of these sets are streamed back to back to check throughput and order. They are followed by an isolated set between bubbles, which separates a correct latency from a stuck or smeared valid. A final reset during a transfer shows whether an in-flight set can leak out.

// File: rtl/sort4_pkg.sv
package sort4_pkg;
  localparam int unsigned NUM_KEYS    = 4;
  localparam int unsigned NUM_LAYERS  = 3;
  localparam int unsigned EARLY_LAYER = 2;
endpackage

// File: rtl/sort4_cmp.sv
module sort4_cmp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  logic swap;
  assign swap = a_i > b_i;
  assign lo_o = swap ? b_i : a_i;
  assign hi_o = swap ? a_i : b_i;
endmodule

// File: rtl/sort4_layer.sv
module sort4_layer
  import sort4_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LAYER  = 0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             valid_i,
  input  logic [NUM_KEYS-1:0][DATA_W-1:0]  keys_i,
  output logic                             valid_o,
  output logic [NUM_KEYS-1:0][DATA_W-1:0]  keys_o
);
  logic [DATA_W-1:0] nxt [NUM_KEYS];

  generate
    if (LAYER == 0) begin : g_pairs
      sort4_cmp #(.DATA_W(DATA_W)) u_a (
        .a_i(keys_i[0]), .b_i(keys_i[1]), .lo_o(nxt[0]), .hi_o(nxt[1]));
      sort4_cmp #(.DATA_W(DATA_W)) u_b (
        .a_i(keys_i[2]), .b_i(keys_i[3]), .lo_o(nxt[2]), .hi_o(nxt[3]));
    end else if (LAYER == 1) begin : g_cross
      // lows meet lows, highs meet highs: lane 0 gets min, lane 3 gets max
      sort4_cmp #(.DATA_W(DATA_W)) u_a (
        .a_i(keys_i[0]), .b_i(keys_i[2]), .lo_o(nxt[0]), .hi_o(nxt[2]));
      sort4_cmp #(.DATA_W(DATA_W)) u_b (
        .a_i(keys_i[1]), .b_i(keys_i[3]), .lo_o(nxt[1]), .hi_o(nxt[3]));
    end else begin : g_middle
      assign nxt[0] = keys_i[0];
      assign nxt[3] = keys_i[3];
      sort4_cmp #(.DATA_W(DATA_W)) u_a (
        .a_i(keys_i[1]), .b_i(keys_i[2]), .lo_o(nxt[1]), .hi_o(nxt[2]));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  // data path carries no reset
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NUM_KEYS; i++) keys_o[i] <= nxt[i];
  end
endmodule

// File: rtl/sort4_pipe.sv
module sort4_pipe
  import sort4_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            in_valid_i,
  input  logic [NUM_KEYS-1:0][DATA_W-1:0] in_keys_i,
  output logic                            out_valid_o,
  output logic [NUM_KEYS-1:0][DATA_W-1:0] out_keys_o,
  output logic                            early_valid_o,
  output logic [DATA_W-1:0]               early_min_o,
  output logic [DATA_W-1:0]               early_max_o
);
  logic [NUM_KEYS-1:0][DATA_W-1:0] key_s [NUM_LAYERS+1];
  logic                            vld_s [NUM_LAYERS+1];

  assign key_s[0] = in_keys_i;
  assign vld_s[0] = in_valid_i;

  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    sort4_layer #(.DATA_W(DATA_W), .LAYER(l)) u_layer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (vld_s[l]),
      .keys_i  (key_s[l]),
      .valid_o (vld_s[l+1]),
      .keys_o  (key_s[l+1])
    );
  end

  assign out_valid_o   = vld_s[NUM_LAYERS];
  assign out_keys_o    = key_s[NUM_LAYERS];
  assign early_valid_o = vld_s[EARLY_LAYER];
  assign early_min_o   = key_s[EARLY_LAYER][0];
  assign early_max_o   = key_s[EARLY_LAYER][NUM_KEYS-1];
endmodule

// File: rtl/sort4_pipe_chk.sv
module sort4_pipe_chk
  import sort4_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            in_valid_i,
  input logic [NUM_KEYS-1:0][DATA_W-1:0] in_keys_i,
  input logic                            out_valid_o,
  input logic [NUM_KEYS-1:0][DATA_W-1:0] out_keys_o,
  input logic                            early_valid_o,
  input logic [DATA_W-1:0]               early_min_o,
  input logic [DATA_W-1:0]               early_max_o
);
  localparam int unsigned SUM_W = DATA_W + 2;

  logic [1:0]       cyc_q;
  logic [SUM_W-1:0] in_sum, out_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  always_comb begin
    in_sum  = '0;
    out_sum = '0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      in_sum  = in_sum  + SUM_W'(in_keys_i[i]);
      out_sum = out_sum + SUM_W'(out_keys_o[i]);
    end
  end

  AST_OUT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_keys_o[0] <= out_keys_o[1]) && (out_keys_o[1] <= out_keys_o[2])
                    && (out_keys_o[2] <= out_keys_o[3])); // R1

  AST_SUM_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3 && out_valid_o) |-> out_sum == $past(in_sum, 3)); // R2

  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> out_valid_o == $past(in_valid_i, 3)); // R3

  AST_EARLY_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> early_valid_o == $past(in_valid_i, 2)); // R5

  AST_EARLY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_valid_o |=> (out_keys_o[0] == $past(early_min_o))
                      && (out_keys_o[NUM_KEYS-1] == $past(early_max_o))); // R5

  AST_EARLY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_valid_o |-> early_min_o <= early_max_o); // R5

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_CLEAR: assert (!out_valid_o && !early_valid_o); // R6
    end
  end
endmodule

bind sort4_pipe sort4_pipe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_keys_i     (in_keys_i),
  .out_valid_o   (out_valid_o),
  .out_keys_o    (out_keys_o),
  .early_valid_o (early_valid_o),
  .early_min_o   (early_min_o),
  .early_max_o   (early_max_o)
);

// File: tb/sim_sort4_pipe.sv
module sim_sort4_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  // lanes 0..3 input, lanes 4..7 expected ascending output
  localparam logic [7:0] TBL [NV][8] = '{
    '{8'd9,   8'd5,   8'd2,   8'd6,   8'd2,  8'd5,   8'd6,   8'd9},
    '{8'd1,   8'd2,   8'd3,   8'd4,   8'd1,  8'd2,   8'd3,   8'd4},
    '{8'd4,   8'd3,   8'd2,   8'd1,   8'd1,  8'd2,   8'd3,   8'd4},
    '{8'd7,   8'd7,   8'd7,   8'd7,   8'd7,  8'd7,   8'd7,   8'd7},
    '{8'd0,   8'd255, 8'd0,   8'd255, 8'd0,  8'd0,   8'd255, 8'd255},
    '{8'd200, 8'd13,  8'd13,  8'd90,  8'd13, 8'd13,  8'd90,  8'd200},
    '{8'd3,   8'd1,   8'd4,   8'd1,   8'd1,  8'd1,   8'd3,   8'd4},
    '{8'd255, 8'd128, 8'd127, 8'd0,   8'd0,  8'd127, 8'd128, 8'd255}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b1;
  logic            in_valid_i = 1'b0;
  logic [3:0][7:0] in_keys_i = '0;
  logic            out_valid_o;
  logic [3:0][7:0] out_keys_o;
  logic            early_valid_o;
  logic [7:0]      early_min_o;
  logic [7:0]      early_max_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  sort4_pipe #(.DATA_W(8)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_keys_i(in_keys_i),
    .out_valid_o(out_valid_o), .out_keys_o(out_keys_o), .early_valid_o(early_valid_o),
    .early_min_o(early_min_o), .early_max_o(early_max_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_vec(input int v);
    return {TBL[v][7], TBL[v][6], TBL[v][5], TBL[v][4]};
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    check(!out_valid_o && !early_valid_o, "R6 reset state", {out_valid_o, early_valid_o}, 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // streamed table, one set per cycle
    for (int k = 0; k <= NV + 1; k++) begin
      @(negedge clk_i);
      if (k < NV) begin
        in_valid_i = 1'b1;
        for (int j = 0; j < 4; j++) in_keys_i[j] = TBL[k][j];
      end else begin
        in_valid_i = 1'b0;
        in_keys_i = 32'hdead_beef;
      end
      @(posedge clk_i);
      #1;
      if (k >= 1 && k - 1 < NV) begin
        check(early_valid_o, "R5 early valid", 32'(early_valid_o), 1);
        check(early_min_o == TBL[k-1][4] && early_max_o == TBL[k-1][7], "R5 early min/max",
              {early_min_o, early_max_o}, {TBL[k-1][4], TBL[k-1][7]});
      end
      if (k >= 2) begin
        check(out_valid_o, "R3 R4 out valid", 32'(out_valid_o), 1);
        check(out_keys_o == exp_vec(k-2), (k == 2) ? "R7 R2 keys" :
              (k == 5 || k == 6) ? "R8 R2 keys" : "R2 R4 keys", out_keys_o, exp_vec(k-2));
        check(out_keys_o[0] <= out_keys_o[1] && out_keys_o[1] <= out_keys_o[2] &&
              out_keys_o[2] <= out_keys_o[3], "R1 ascending", out_keys_o, exp_vec(k-2));
      end
    end

    // isolated set between bubbles
    @(negedge clk_i);
    in_valid_i = 1'b0;
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_keys_i = {8'd40, 8'd10, 8'd30, 8'd20};
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_keys_i = {8'd1, 8'd2, 8'd3, 8'd4};
    for (int e = 1; e <= 4; e++) begin
      if (e > 1) @(negedge clk_i);
      @(posedge clk_i);
      #1;
      check(out_valid_o == (e == 2), "R9 bubble out_valid", 32'(out_valid_o), 32'(e == 2));
      check(early_valid_o == (e == 1), "R9 bubble early_valid", 32'(early_valid_o),
            32'(e == 1));
      if (e == 2)
        check(out_keys_o == {8'd40, 8'd30, 8'd20, 8'd10}, "R3 isolated keys", out_keys_o,
              {8'd40, 8'd30, 8'd20, 8'd10});
    end

    // reset with a set in flight
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_keys_i = {8'd5, 8'd6, 8'd7, 8'd8};
    @(negedge clk_i);
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check(!out_valid_o && !early_valid_o, "R6 flush", {out_valid_o, early_valid_o}, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    for (int e = 0; e < 4; e++) begin
      @(posedge clk_i);
      #1;
      check(!out_valid_o && !early_valid_o, "R6 no leak", {out_valid_o, early_valid_o}, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule